// File: doc/BRIEF.md
# Packet-Driven Cabinet I/O Controller

This block sits between a byte-serial packet bus and a local logic payload. Each incoming packet is a fixed 16-byte frame; the controller collects it, splits it into a header (packet type, sender MAC address, source unit type, info type) and a 49-bit signal record (CPU strobes, address, data, status flags, control word). It then picks one of four outcomes: drop the packet, acknowledge it without touching the payload, load its record into the payload inputs and acknowledge, or load the record, wait a programmable number of cycles for the payload to settle, capture the payload outputs and return them in a Response packet.

The payload sees two input buffers. One holds the record now applied and the other holds the record applied before it, so the payload can find rising edges on control bits. A ready-made rising-edge vector for the control word is also provided. Transmitted frames use this unit's own MAC address and unit type, and reception stays closed until the last byte of a reply has left.

Top module: `cio_ctrl`

## Requirements
- R1: A frame is 16 bytes taken on rx_valid && rx_ready, in this order: byte 0 packet type, bytes 1-6 MAC (most significant byte first), byte 7 source unit type, byte 8 info type, byte 9 CPU strobes in bits [3:0] (bit3 read_n, bit2 write_n, bit1 reset_n, bit0 busy_n), bytes 10-11 address (high byte first), byte 12 data, byte 13 status in bits [4:0], bytes 14-15 control word (high byte first, instruction field in bits [4:0]).
- R2: A frame whose packet type is not 0x01, or whose MAC equals the SELF_MAC parameter, is dropped: no byte is sent, the payload buffers keep their values and rx_ready returns high.
- R3: A general data frame (type 0x01) whose info type is 8 or more, or whose bit in UPD_INFO_MASK is clear, leaves both payload buffers unchanged and is answered with an Acknowledge.
- R4: A general data frame whose info-type bit in UPD_INFO_MASK is set copies the present pl_new into pl_old and loads its record into pl_new, packed as {cpu[3:0], addr[15:0], data[7:0], status[4:0], ctrl[15:0]} (bits 48 down to 0).
- R5: ctrl_rise has a bit set for each control-word bit that is 1 in pl_new and 0 in pl_old.
- R6: For an updating frame whose source unit type bit in RESP_SRC_MASK is set, pl_out is captured after the delay dly_cycles (0 counts as 1), and the first reply byte is presented 1 + max(dly_cycles,1) cycles after the clock edge that accepted the frame's last byte.
- R7: A Response is 16 bytes in the R1 layout: type 0x02, SELF_MAC, SELF_UNIT, the received info type, then the captured pl_out fields with unused bits zero; tx_last is high on byte 15 only.
- R8: An Acknowledge is 9 bytes: type 0x03, SELF_MAC, SELF_UNIT and the received info type, with tx_last on byte 8; its first byte is presented one cycle after the last received byte is accepted.
- R9: rx_ready stays low from the last byte of a frame until the last reply byte is accepted; while tx_valid is high and tx_ready low, tx_data and tx_last hold.
- R10: After reset rx_ready is high, tx_valid is low and pl_new and pl_old are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Controller can take a byte |
| rx_data | input | 8 | Incoming byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_ready | input | 1 | Receiver takes the outgoing byte |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte ends its packet |
| dly_cycles | input | DLY_W | Payload settle time in cycles |
| pl_new | output | 49 | Record applied to the payload now |
| pl_old | output | 49 | Record applied before the current one |
| ctrl_rise | output | 16 | Control bits that went from 0 to 1 |
| pl_out | input | 49 | Payload outputs, same packing as pl_new |

## Verification
The two functions that can meet in one cycle are reply transmission and frame reception: the bench holds rx_valid high with a stray byte for the whole time a Response is being sent, while it also drops tx_ready every third cycle. It judges the overlap by seeing rx_ready low on every cycle of the reply, every reply byte correct despite the stalls, and the next frame decoded into pl_new with no trace of the stray byte.

// File: rtl/cio_pkg.sv
package cio_pkg;

  localparam int MAC_BYTES  = 6;
  localparam int HDR_BYTES  = 3 + MAC_BYTES;
  localparam int BODY_BYTES = 7;
  localparam int PKT_BYTES  = HDR_BYTES + BODY_BYTES;
  localparam int FRAME_W    = 8 * PKT_BYTES;
  localparam int MAC_W      = 8 * MAC_BYTES;
  localparam int TYPE_SLOTS = 8;

  localparam logic [7:0] PT_DATA = 8'h01;
  localparam logic [7:0] PT_RESP = 8'h02;
  localparam logic [7:0] PT_ACK  = 8'h03;

  typedef struct packed {
    logic [3:0]  cpu;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [4:0]  status;
    logic [15:0] ctrl;
  } cab_sig_t;

  localparam int SIG_W = $bits(cab_sig_t);

  typedef struct packed {
    logic [7:0]       ptype;
    logic [MAC_W-1:0] mac;
    logic [7:0]       src;
    logic [7:0]       info;
    cab_sig_t         sig;
  } pkt_t;

  // on-the-wire image of a frame, byte 0 in the top bits
  typedef struct packed {
    logic [7:0]       ptype;
    logic [MAC_W-1:0] mac;
    logic [7:0]       src;
    logic [7:0]       info;
    logic [3:0]       cpu_pad;
    logic [3:0]       cpu;
    logic [15:0]      addr;
    logic [7:0]       data;
    logic [2:0]       st_pad;
    logic [4:0]       status;
    logic [15:0]      ctrl;
  } wire_t;

  typedef enum logic [1:0] {ACT_DROP, ACT_IGNORE, ACT_SILENT, ACT_RESPOND} act_e;

  function automatic logic [7:0] frame_byte(logic [FRAME_W-1:0] f, int unsigned k);
    return f[FRAME_W-1-8*k -: 8];
  endfunction

  function automatic pkt_t frame_decode(logic [FRAME_W-1:0] f);
    wire_t w;
    pkt_t  p;
    w = wire_t'(f);
    p.ptype      = w.ptype;
    p.mac        = w.mac;
    p.src        = w.src;
    p.info       = w.info;
    p.sig.cpu    = w.cpu;
    p.sig.addr   = w.addr;
    p.sig.data   = w.data;
    p.sig.status = w.status;
    p.sig.ctrl   = w.ctrl;
    return p;
  endfunction

  function automatic logic [FRAME_W-1:0] frame_encode(pkt_t p);
    wire_t w;
    w        = '0;
    w.ptype  = p.ptype;
    w.mac    = p.mac;
    w.src    = p.src;
    w.info   = p.info;
    w.cpu    = p.sig.cpu;
    w.addr   = p.sig.addr;
    w.data   = p.sig.data;
    w.status = p.sig.status;
    w.ctrl   = p.sig.ctrl;
    return FRAME_W'(w);
  endfunction

  function automatic act_e classify(pkt_t p, logic [MAC_W-1:0] self_mac,
                                    logic [TYPE_SLOTS-1:0] upd_info,
                                    logic [TYPE_SLOTS-1:0] resp_src);
    if (p.ptype != PT_DATA || p.mac == self_mac) return ACT_DROP;
    if (p.info >= 8'(TYPE_SLOTS)) return ACT_IGNORE;
    if (!upd_info[p.info[2:0]]) return ACT_IGNORE;
    if (p.src < 8'(TYPE_SLOTS) && resp_src[p.src[2:0]]) return ACT_RESPOND;
    return ACT_SILENT;
  endfunction

  function automatic logic [15:0] rising(logic [15:0] now_v, logic [15:0] prev_v);
    return now_v & ~prev_v;
  endfunction

endpackage

// File: rtl/cio_rx_parser.sv
module cio_rx_parser import cio_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [7:0]         byte_in,
  output logic               last_beat,
  output logic [FRAME_W-1:0] frame
);
  localparam int IDX_W = $clog2(PKT_BYTES);

  logic [IDX_W-1:0] idx;

  assign last_beat = take && (idx == IDX_W'(PKT_BYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      frame <= '0;
    end else if (take) begin
      frame <= {frame[FRAME_W-9:0], byte_in};
      idx   <= last_beat ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/cio_delay.sv
module cio_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expire
);
  logic [W-1:0] cnt;
  logic         run;

  assign expire = run && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= (len == '0) ? W'(1) : len;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == W'(1)) run <= 1'b0;
      else              cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cio_tx_ser.sv
module cio_tx_ser import cio_pkg::*; (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               short_pkt,
  input  logic [FRAME_W-1:0] frame,
  input  logic               tx_ready,
  output logic               tx_valid,
  output logic [7:0]         tx_data,
  output logic               tx_last,
  output logic               done
);
  localparam int IDX_W = $clog2(PKT_BYTES);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] final_idx;

  assign final_idx = short_pkt ? IDX_W'(HDR_BYTES - 1) : IDX_W'(PKT_BYTES - 1);
  assign tx_valid  = active;
  assign tx_data   = frame_byte(frame, 32'(idx));
  assign tx_last   = active && (idx == final_idx);
  assign done      = tx_valid && tx_ready && tx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idx <= '0;
    else if (tx_valid && tx_ready) idx <= tx_last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/cio_ctrl.sv
module cio_ctrl import cio_pkg::*; #(
  parameter logic [MAC_W-1:0]      SELF_MAC      = 48'h02_00_5E_10_00_07,
  parameter logic [7:0]            SELF_UNIT     = 8'h02,
  parameter logic [TYPE_SLOTS-1:0] UPD_INFO_MASK = 8'h0E,
  parameter logic [TYPE_SLOTS-1:0] RESP_SRC_MASK = 8'h02,
  parameter int                    DLY_W         = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [7:0]       rx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic [DLY_W-1:0] dly_cycles,
  output logic [SIG_W-1:0] pl_new,
  output logic [SIG_W-1:0] pl_old,
  output logic [15:0]      ctrl_rise,
  input  logic [SIG_W-1:0] pl_out
);
  typedef enum logic [1:0] {ST_RECV, ST_DECIDE, ST_WAIT, ST_SEND} st_e;

  st_e                state;
  logic [FRAME_W-1:0] rx_frame;
  logic [FRAME_W-1:0] tx_frame;
  pkt_t               rx_pkt;
  pkt_t               reply;
  act_e               act;
  cab_sig_t           new_buf, old_buf, out_buf;
  logic [7:0]         reply_info;
  logic               reply_ack;

  // named internal events
  logic take, pkt_done, apply_ev, wait_load, capture_ev, tx_done;

  assign rx_ready  = (state == ST_RECV);
  assign take      = rx_valid && rx_ready;
  assign rx_pkt    = frame_decode(rx_frame);
  assign act       = classify(rx_pkt, SELF_MAC, UPD_INFO_MASK, RESP_SRC_MASK);
  assign apply_ev  = (state == ST_DECIDE) && (act == ACT_SILENT || act == ACT_RESPOND);
  assign wait_load = (state == ST_DECIDE) && (act == ACT_RESPOND);

  cio_rx_parser u_rx (
    .clk(clk), .rst_n(rst_n), .take(take), .byte_in(rx_data),
    .last_beat(pkt_done), .frame(rx_frame)
  );

  cio_delay #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(wait_load), .len(dly_cycles), .expire(capture_ev)
  );

  always_comb begin
    reply.ptype = reply_ack ? PT_ACK : PT_RESP;
    reply.mac   = SELF_MAC;
    reply.src   = SELF_UNIT;
    reply.info  = reply_info;
    reply.sig   = reply_ack ? cab_sig_t'('0) : out_buf;
  end
  assign tx_frame = frame_encode(reply);

  cio_tx_ser u_tx (
    .clk(clk), .rst_n(rst_n), .active(state == ST_SEND), .short_pkt(reply_ack),
    .frame(tx_frame), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .done(tx_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_RECV;
      new_buf    <= '0;
      old_buf    <= '0;
      out_buf    <= '0;
      reply_info <= '0;
      reply_ack  <= 1'b1;
    end else begin
      if (apply_ev) begin
        old_buf <= new_buf;
        new_buf <= rx_pkt.sig;
      end
      case (state)
        ST_RECV:   if (pkt_done) state <= ST_DECIDE;
        ST_DECIDE: begin
          reply_info <= rx_pkt.info;
          reply_ack  <= (act != ACT_RESPOND);
          case (act)
            ACT_DROP:    state <= ST_RECV;
            ACT_RESPOND: state <= ST_WAIT;
            default:     state <= ST_SEND;
          endcase
        end
        ST_WAIT: if (capture_ev) begin
          out_buf <= cab_sig_t'(pl_out);
          state   <= ST_SEND;
        end
        ST_SEND: if (tx_done) state <= ST_RECV;
        default: state <= ST_RECV;
      endcase
    end
  end

  assign pl_new    = new_buf;
  assign pl_old    = old_buf;
  assign ctrl_rise = rising(new_buf.ctrl, old_buf.ctrl);
endmodule

// File: rtl/cio_ctrl_chk.sv
module cio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic [48:0] pl_new,
  input logic [48:0] pl_old
);
  logic       first_byte;
  logic [4:0] sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_byte <= 1'b1;
      sent       <= '0;
    end else if (tx_valid && tx_ready) begin
      first_byte <= tx_last;
      sent       <= tx_last ? 5'd0 : sent + 5'd1;
    end
  end

  // R9
  rx_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4
  old_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_new != $past(pl_new)) |-> (pl_old == $past(pl_new)));

  // R7
  tx_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && first_byte) |-> (tx_data == 8'h02 || tx_data == 8'h03));

  // R8
  tx_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && (sent == 5'd8 || sent == 5'd15)));
endmodule

bind cio_ctrl cio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
  .pl_new(pl_new), .pl_old(pl_old)
);

// File: tb/sim_cio_ctrl.sv
module sim_cio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] OWN_MAC  = 48'h02_00_5E_10_00_07;
  localparam logic [47:0] PEER_MAC = 48'h02_00_5E_10_00_01;
  localparam logic [7:0]  OWN_UNIT = 8'h02;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, tx_ready = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_ready, tx_valid, tx_last;
  logic [7:0]  tx_data;
  logic [7:0]  dly_cycles = 8'd3;
  logic [48:0] pl_new, pl_old, pl_out;
  logic [15:0] ctrl_rise;

  always #(CLK_PERIOD/2) clk = ~clk;

  cio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .dly_cycles(dly_cycles), .pl_new(pl_new), .pl_old(pl_old), .ctrl_rise(ctrl_rise),
    .pl_out(pl_out)
  );

  // payload model: inverts its inputs
  assign pl_out = ~pl_new;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [7:0]  pk [16];
  logic [7:0]  got [40];
  int          got_n, lat, t_acc;
  bit          rx_leak;
  logic [48:0] exp_new, exp_old;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic mk(logic [7:0] pt, logic [47:0] mac, logic [7:0] src, logic [7:0] info,
                    logic [3:0] cpu, logic [15:0] addr, logic [7:0] data,
                    logic [4:0] st, logic [15:0] ctrl);
    pk[0] = pt;
    for (int k = 0; k < 6; k++) pk[1+k] = mac[47-8*k -: 8];
    pk[7] = src;  pk[8] = info;   pk[9] = {4'h0, cpu};
    pk[10] = addr[15:8]; pk[11] = addr[7:0]; pk[12] = data;
    pk[13] = {3'b000, st}; pk[14] = ctrl[15:8]; pk[15] = ctrl[7:0];
  endtask

  function automatic logic [48:0] rec_of_pk();
    return {pk[9][3:0], pk[10], pk[11], pk[12], pk[13][4:0], pk[14], pk[15]};
  endfunction

  task automatic put_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_pkt();
    for (int k = 0; k < 16; k++) put_byte(pk[k]);
    t_acc = cyc;
  endtask

  task automatic recv(bit stall, bit hold_rx);
    bit last;
    got_n = 0; rx_leak = 0; last = 0;
    if (hold_rx) begin rx_valid = 1'b1; rx_data = 8'hEE; end
    while (!tx_valid && (cyc - t_acc) < 400) begin
      if (rx_ready) rx_leak = 1;
      @(negedge clk);
    end
    lat = cyc - t_acc;
    while (!last && got_n < 40 && (cyc - t_acc) < 600) begin
      if (rx_ready) rx_leak = 1;
      tx_ready = (stall && (cyc % 3 == 0)) ? 1'b0 : 1'b1;
      if (tx_valid && tx_ready) begin
        got[got_n] = tx_data; got_n++; last = tx_last;
      end
      @(negedge clk);
    end
    rx_valid = 1'b0;
    tx_ready = 1'b0;
  endtask

  task automatic check_reply(string req, bit ack, logic [48:0] outv, logic [7:0] info);
    logic [7:0] e [16];
    int n, bad;
    e[0] = ack ? 8'h03 : 8'h02;
    for (int k = 0; k < 6; k++) e[1+k] = OWN_MAC[47-8*k -: 8];
    e[7] = OWN_UNIT; e[8] = info; e[9] = {4'h0, outv[48:45]};
    e[10] = outv[44:37]; e[11] = outv[36:29]; e[12] = outv[28:21];
    e[13] = {3'b000, outv[20:16]}; e[14] = outv[15:8]; e[15] = outv[7:0];
    n = ack ? 9 : 16;
    chk(req, "reply length", 64'(got_n), 64'(n));
    bad = -1;
    for (int k = 0; k < n && k < got_n; k++) if (bad < 0 && got[k] !== e[k]) bad = k;
    if (bad >= 0) chk(req, $sformatf("reply byte %0d", bad), 64'(got[bad]), 64'(e[bad]));
    else          chk(req, "reply bytes", 64'(0), 64'(0));
  endtask

  task automatic t_reset();
    chk("R10", "rx_ready", 64'(rx_ready), 64'(1));
    chk("R10", "tx_valid", 64'(tx_valid), 64'(0));
    chk("R10", "pl_new", 64'(pl_new), 64'(0));
    chk("R10", "pl_old", 64'(pl_old), 64'(0));
  endtask

  task automatic t_respond(logic [7:0] d, logic [15:0] ctrl, bit stall, bit hold_rx);
    int d_eff;
    dly_cycles = d;
    d_eff = (d == 0) ? 1 : int'(d);
    mk(8'h01, PEER_MAC, 8'h01, 8'h01, 4'hA, 16'h1234 + 16'(d), 8'h5C, 5'h13, ctrl);
    send_pkt();
    exp_old = exp_new; exp_new = rec_of_pk();
    recv(stall, hold_rx);
    chk("R6", "response latency", 64'(lat), 64'(1 + d_eff));
    check_reply("R7", 1'b0, ~exp_new, 8'h01);
    chk("R4", "pl_new after respond", 64'(pl_new), 64'(exp_new));
    chk("R4", "pl_old after respond", 64'(pl_old), 64'(exp_old));
    chk("R9", "rx_ready low during reply", 64'(rx_leak), 64'(0));
  endtask

  task automatic t_silent(logic [15:0] ctrl, logic [7:0] src);
    logic [15:0] prev_ctrl;
    prev_ctrl = exp_new[15:0];
    mk(8'h01, PEER_MAC, src, 8'h02, 4'h5, 16'hBEEF, 8'h81, 5'h0C, ctrl);
    send_pkt();
    exp_old = exp_new; exp_new = rec_of_pk();
    recv(1'b0, 1'b0);
    chk("R8", "ack latency", 64'(lat), 64'(1));
    check_reply("R8", 1'b1, '0, 8'h02);
    chk("R4", "pl_new after silent", 64'(pl_new), 64'(exp_new));
    chk("R4", "pl_old after silent", 64'(pl_old), 64'(exp_old));
    chk("R5", "ctrl_rise", 64'(ctrl_rise), 64'(ctrl & ~prev_ctrl));
  endtask

  task automatic t_ignore(logic [7:0] info);
    mk(8'h01, PEER_MAC, 8'h01, info, 4'h3, 16'h0F0F, 8'h11, 5'h1F, 16'hFFFF);
    send_pkt();
    recv(1'b0, 1'b0);
    check_reply("R3", 1'b1, '0, info);
    chk("R3", "pl_new unchanged", 64'(pl_new), 64'(exp_new));
    chk("R3", "pl_old unchanged", 64'(pl_old), 64'(exp_old));
  endtask

  task automatic t_drop(logic [7:0] pt, logic [47:0] mac, string what);
    bit seen;
    mk(pt, mac, 8'h01, 8'h01, 4'h1, 16'h7777, 8'h22, 5'h01, 16'hAAAA);
    send_pkt();
    seen = 0;
    repeat (20) begin @(negedge clk); if (tx_valid) seen = 1; end
    chk("R2", {what, " no reply"}, 64'(seen), 64'(0));
    chk("R2", {what, " rx_ready"}, 64'(rx_ready), 64'(1));
    chk("R2", {what, " pl_new kept"}, 64'(pl_new), 64'(exp_new));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    exp_new = '0; exp_old = '0;
    repeat (2) @(negedge clk);
    t_respond(8'd3, 16'h00F1, 1'b0, 1'b0);   // R1 frame layout, R6, R7
    t_silent(16'h0F0F, 8'h03);                 // R4, R5, R8
    t_silent(16'h0F0E, 8'h09);                 // source type out of mask range
    t_ignore(8'h05);                           // R3 info bit clear
    t_ignore(8'h20);                           // R3 info type >= 8
    t_drop(8'h07, PEER_MAC, "unknown type");
    t_drop(8'h02, PEER_MAC, "response type");
    t_drop(8'h01, OWN_MAC, "own mac");
    t_respond(8'd0, 16'h8001, 1'b0, 1'b0);     // R6 zero counts as one
    t_respond(8'd255, 16'h0002, 1'b0, 1'b0);   // R6 longest wait
    t_respond(8'd2, 16'h4000, 1'b1, 1'b1);     // R9 stall plus held rx
    t_silent(16'h1234, 8'h04);                 // R9 next frame clean
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule